// File: doc/BRIEF.md
# Serial Core Run-State Controller

This block sequences a serial bus engine between three operating conditions: held in reset, running, and paused. Software asks for a condition by writing a 2-bit code. A legal request is not applied at once. The controller starts a settling window of a fixed number of clock cycles, and the new condition takes effect when that window closes. While the window is open, a valid flag in the status word reads low. Software polls the status word and trusts the reported state only when that flag is high. Requests that arrive while the flag is low are dropped.

A separate one-shot software reset pulse forces the reset condition at once, whatever is in progress, and opens a fresh settling window. Entering the reset condition also clears a latched error interrupt. The controller drives three plain control levels to the downstream bus sequencer. The enable level lets it operate. The hold level makes it stop fetching new queue entries while it keeps its bus state. The clear level flushes its queues and zeroes its transfer counters. The status word also passes through a ready flag that the sequencer's bus master supplies.

The two clock domains of a real engine are modelled here as one clock. The settling window is a single counter of `SETTLE` cycles, six by default.

Top module: `sercore_runstate`

## Requirements
- R1: After reset is released, the status word reports state code 0 with the valid flag high, `err_irq` is low, `seq_clear` is high, and `seq_en` and `seq_hold` are low.
- R2: `status` bits [1:0] hold the state code (reset = 0, run = 1, pause = 3). Bit 2 is the valid flag, bit 3 always reads 0, and bit 4 follows the `seq_rdy` input in the same cycle.
- R3: A write with code 0, 1 or 3 made while the valid flag is high is accepted, even when the code equals the current state. From the cycle after the write, valid reads low for exactly `SETTLE` cycles and the old state code stays visible. The new code then appears in the same cycle as valid returns high.
- R4: A write made while the valid flag is low has no effect, including a write in the last cycle of the settling window. The window and the code it ends with are unchanged.
- R5: A write of code 2 is ignored. Valid stays high and the state code is unchanged.
- R6: A `sw_rst` pulse is taken whatever the valid flag reads, and it overrides a write in the same cycle. In the next cycle the state code reads 0 and valid reads low, and valid returns high `SETTLE` cycles after the pulse, with state 0.
- R7: An `err_evt` pulse sets `err_irq`, which holds until the reset state is entered. It clears in the cycle after a `sw_rst` pulse, and in the same cycle that a write of code 0 takes effect. A clear wins over a set in the same cycle.
- R8: The sequencer controls follow the reported state code. In run: `seq_en`=1, `seq_hold`=0, `seq_clear`=0. In pause: `seq_en`=1, `seq_hold`=1, `seq_clear`=0. In reset: `seq_en`=0, `seq_hold`=0, `seq_clear`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all state |
| rst_n | input | 1 | Active-low asynchronous reset |
| st_wr | input | 1 | Strobe: write a requested state code |
| st_wdata | input | 2 | Requested state code |
| sw_rst | input | 1 | One-shot software reset pulse |
| err_evt | input | 1 | Error event that sets the interrupt |
| seq_rdy | input | 1 | Bus master ready, passed into status bit 4 |
| status | output | 5 | Status word: state, valid, master ready |
| err_irq | output | 1 | Latched error interrupt |
| seq_en | output | 1 | Sequencer enable |
| seq_hold | output | 1 | Sequencer hold: stop fetching, keep bus state |
| seq_clear | output | 1 | Sequencer clear: flush queues, zero counters |

## Verification
On every cycle, the assertions check four things. An accepted write drops the valid flag while the state holds. The end of the window commits the pending code. Writes made during the window and writes of code 2 leave the state untouched. The software reset and interrupt-clear rules hold, and the sequencer controls match the state code. Only the bench's scenarios can show that the valid flag stays low for exactly `SETTLE` cycles, and it does this for every pairing of start state and written code. The bench also shows the exact cycle in which the interrupt clears, and that a write in the window's final cycle changes nothing.

// File: rtl/sercore_rs_pkg.sv
package sercore_rs_pkg;
  typedef enum logic [1:0] {
    RS_IDLE  = 2'd0,
    RS_RUN   = 2'd1,
    RS_PAUSE = 2'd3
  } rs_state_e;

  localparam int STATUS_W  = 5;
  localparam int VALID_BIT = 2;
  localparam int MRDY_BIT  = 4;

  // code 2 has no meaning and is dropped (R5)
  function automatic logic code_legal(input logic [1:0] code);
    return code != 2'd2;
  endfunction
endpackage

// File: rtl/sercore_rs_timer.sv
module sercore_rs_timer #(
  parameter int SETTLE = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic done
);
  localparam int CW = (SETTLE > 2) ? $clog2(SETTLE) : 1;
  localparam logic [CW-1:0] LOAD = CW'(SETTLE - 1);

  logic [CW-1:0] cnt_q;

  assign done = busy && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      cnt_q <= '0;
    end else if (start) begin
      busy  <= 1'b1;
      cnt_q <= LOAD;
    end else if (busy) begin
      if (cnt_q == '0) busy <= 1'b0;
      else             cnt_q <= cnt_q - 1'b1;
    end
  end

  // R3: window stays open until the count runs out
  p_window_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy);
  // R3: window closes after the last count unless restarted
  p_window_ends_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> !busy);
endmodule

// File: rtl/sercore_rs_irq.sv
module sercore_rs_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic err_evt,
  input  logic clr,
  output logic irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        irq <= 1'b0;
    else if (clr)      irq <= 1'b0;
    else if (err_evt)  irq <= 1'b1;
  end

  // R7: clearing wins over a simultaneous event
  p_clear_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !irq);
  // R7: an event with no clear latches
  p_event_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (err_evt && !clr) |=> irq);
endmodule

// File: rtl/sercore_rs_drive.sv
module sercore_rs_drive
  import sercore_rs_pkg::*;
(
  input  rs_state_e st,
  output logic      en,
  output logic      hold,
  output logic      clear
);
  always_comb begin
    en    = 1'b0;
    hold  = 1'b0;
    clear = 1'b0;
    unique case (st)
      RS_RUN:   en = 1'b1;
      RS_PAUSE: begin en = 1'b1; hold = 1'b1; end
      default:  clear = 1'b1;
    endcase
  end
endmodule

// File: rtl/sercore_runstate.sv
module sercore_runstate
  import sercore_rs_pkg::*;
#(
  parameter int SETTLE = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                st_wr,
  input  logic [1:0]          st_wdata,
  input  logic                sw_rst,
  input  logic                err_evt,
  input  logic                seq_rdy,
  output logic [STATUS_W-1:0] status,
  output logic                err_irq,
  output logic                seq_en,
  output logic                seq_hold,
  output logic                seq_clear
);
  logic      busy, done, accept, start, irq_clr;
  rs_state_e cur_q, pend_q;

  assign accept  = st_wr && !busy && code_legal(st_wdata);
  assign start   = sw_rst || accept;
  assign irq_clr = sw_rst || (done && pend_q == RS_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q  <= RS_IDLE;
      pend_q <= RS_IDLE;
    end else if (sw_rst) begin
      cur_q  <= RS_IDLE;
      pend_q <= RS_IDLE;
    end else begin
      if (accept) pend_q <= rs_state_e'(st_wdata);
      if (done)   cur_q  <= pend_q;
    end
  end

  sercore_rs_timer #(.SETTLE(SETTLE)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done)
  );

  sercore_rs_irq u_irq (
    .clk(clk), .rst_n(rst_n), .err_evt(err_evt), .clr(irq_clr), .irq(err_irq)
  );

  sercore_rs_drive u_drive (
    .st(cur_q), .en(seq_en), .hold(seq_hold), .clear(seq_clear)
  );

  always_comb begin
    status            = '0;
    status[1:0]       = cur_q;
    status[VALID_BIT] = !busy;
    status[MRDY_BIT]  = seq_rdy;
  end

  // R3: an accepted request drops valid and keeps the old state
  p_accept_drops_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !sw_rst) |=> !status[VALID_BIT] && $stable(cur_q));
  // R3: closing the window commits the pending code
  p_commit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !sw_rst) |=> status[VALID_BIT] && status[1:0] == $past(pend_q));
  // R4: writes inside the window change nothing
  p_busy_write_ignored_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_wr && busy && !done && !sw_rst) |=> $stable(cur_q) && $stable(pend_q));
  // R5: code 2 is dropped
  p_bad_code_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_wr && !busy && st_wdata == 2'd2 && !sw_rst) |=> status[VALID_BIT] && $stable(cur_q));
  // R6: software reset forces state 0 and opens a window
  p_swrst_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sw_rst |=> status[1:0] == 2'd0 && !status[VALID_BIT]);
  // R8: controls match the reported state
  p_pause_drive_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_q == RS_PAUSE) |-> seq_en && seq_hold && !seq_clear);
  p_idle_drive_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_q == RS_IDLE) |-> !seq_en && !seq_hold && seq_clear);
endmodule

// File: tb/sercore_runstate_tb.sv
module sercore_runstate_tb;
  localparam int SETTLE = 6;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       st_wr = 1'b0;
  logic [1:0] st_wdata = 2'd0;
  logic       sw_rst = 1'b0;
  logic       err_evt = 1'b0;
  logic       seq_rdy = 1'b0;
  logic [4:0] status;
  logic       err_irq, seq_en, seq_hold, seq_clear;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  sercore_runstate #(.SETTLE(SETTLE)) u_dut (
    .clk(clk), .rst_n(rst_n), .st_wr(st_wr), .st_wdata(st_wdata),
    .sw_rst(sw_rst), .err_evt(err_evt), .seq_rdy(seq_rdy), .status(status),
    .err_irq(err_irq), .seq_en(seq_en), .seq_hold(seq_hold), .seq_clear(seq_clear)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  // R8 mapping computed from the state code
  task automatic check_state(input string tag, input int s, input int v);
    chk({tag, " state"}, int'(status[1:0]), s);
    chk({tag, " valid"}, int'(status[2]), v);
    chk({tag, " R8 en"}, int'(seq_en), (s == 1 || s == 3) ? 1 : 0);
    chk({tag, " R8 hold"}, int'(seq_hold), (s == 3) ? 1 : 0);
    chk({tag, " R8 clear"}, int'(seq_clear), (s == 0) ? 1 : 0);
  endtask

  task automatic write_code(input int c);
    st_wr = 1'b1;
    st_wdata = 2'(c);
    @(posedge clk);
    @(negedge clk);
    st_wr = 1'b0;
  endtask

  // entered at the negedge after the accepting edge (index 0)
  task automatic settle_check(input string tag, input int old_s, input int new_s);
    for (int i = 0; i < SETTLE; i++) begin
      check_state(tag, old_s, 0);
      @(negedge clk);
    end
    check_state(tag, new_s, 1);
  endtask

  task automatic soft_reset();
    sw_rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    sw_rst = 1'b0;
    settle_check("R6", 0, 0);
  endtask

  task automatic go_state(input int s);
    soft_reset();
    if (s != 0) begin
      write_code(s);
      settle_check("R3", 0, s);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
    $finish;
  end

  initial begin
    int starts[3];
    starts[0] = 0; starts[1] = 1; starts[2] = 3;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_state("R1", 0, 1);
    chk("R1 irq", int'(err_irq), 0);

    // R2: status bit layout
    for (int v = 0; v < 2; v++) begin
      seq_rdy = v[0];
      #1;
      chk("R2 ready bit", int'(status[4]), v);
      chk("R2 spare bit", int'(status[3]), 0);
    end
    @(negedge clk);

    // R3 / R5 sweep: every start state against every code
    foreach (starts[k]) begin
      for (int c = 0; c < 4; c++) begin
        go_state(starts[k]);
        write_code(c);
        if (c == 2) begin
          check_state("R5", starts[k], 1);
          @(negedge clk);
          check_state("R5", starts[k], 1);
        end else begin
          settle_check("R3", starts[k], c);
        end
      end
    end

    // R4: write in the middle of the window
    go_state(0);
    write_code(1);
    check_state("R4", 0, 0);
    @(negedge clk);
    write_code(3);
    for (int i = 2; i < SETTLE; i++) begin
      check_state("R4", 0, 0);
      @(negedge clk);
    end
    check_state("R4", 1, 1);
    @(negedge clk);
    check_state("R4", 1, 1);

    // R4: write in the last cycle of the window
    go_state(0);
    write_code(3);
    for (int i = 0; i < SETTLE - 1; i++) begin
      check_state("R4", 0, 0);
      @(negedge clk);
    end
    write_code(1);
    check_state("R4 last", 3, 1);
    @(negedge clk);
    check_state("R4 last", 3, 1);

    // R6: software reset mid-window overrides a same-cycle write
    go_state(0);
    write_code(1);
    @(negedge clk);
    @(negedge clk);
    sw_rst = 1'b1; st_wr = 1'b1; st_wdata = 2'd3;
    @(posedge clk);
    @(negedge clk);
    sw_rst = 1'b0; st_wr = 1'b0;
    settle_check("R6", 0, 0);
    @(negedge clk);
    check_state("R6 after", 0, 1);

    // R7: interrupt latch and clear on reset entry
    err_evt = 1'b1;
    @(posedge clk); @(negedge clk);
    err_evt = 1'b0;
    chk("R7 set", int'(err_irq), 1);
    write_code(1);
    settle_check("R3", 0, 1);
    chk("R7 held in run", int'(err_irq), 1);
    write_code(0);
    for (int i = 0; i < SETTLE; i++) begin
      chk("R7 held in window", int'(err_irq), 1);
      @(negedge clk);
    end
    chk("R7 cleared on entry", int'(err_irq), 0);
    check_state("R7", 0, 1);
    err_evt = 1'b1;
    @(posedge clk); @(negedge clk);
    err_evt = 1'b0;
    chk("R7 set again", int'(err_irq), 1);
    sw_rst = 1'b1;
    @(posedge clk); @(negedge clk);
    sw_rst = 1'b0;
    chk("R7 cleared by sw reset", int'(err_irq), 0);
    err_evt = 1'b1; sw_rst = 1'b1;
    @(posedge clk); @(negedge clk);
    err_evt = 1'b0; sw_rst = 1'b0;
    chk("R7 clear wins", int'(err_irq), 0);

    summary();
    $finish;
  end
endmodule